// File: doc/BRIEF.md
# General-Purpose Pin Bank Controller

This block manages a bank of general-purpose pins. Software uses it through a small register bus. For each pin it chooses one of two owners. If the controller owns the pin, the pin is a software input or output. If not, an on-chip peripheral drives the pad directly. Every pin has its own settings for owner, direction, output value, glitch filter and change interrupt. Each setting is changed through a pair of strobe addresses, one that sets bits and one that clears them. Software can therefore change one pin without reading the register first.

Each pad input passes through a two-stage synchronizer. An optional per-pin filter follows, which accepts a new level only after it has been seen on two samples in a row. The result is the pin's level. Software can read it, and peripherals receive it. Any change of that level, rising or falling, sets a sticky bit in a change register. Reading the change register clears it. The interrupt output is high while any set change bit belongs to a pin whose interrupt is enabled. A chip with many pins uses several copies of this bank side by side.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset the controller owns every pin. Also after reset: all pins are inputs, output data is 0, filters and interrupt enables are off, the change register is 0, `irq` is low and `pad_oe` is 0.
- R2: Each setting has three word addresses, laid out as `bus_addr[4:2]` = group and `bus_addr[1:0]` = operation. The groups are owner=0, direction=1, output data=2, filter=3 and interrupt enable=4. The operations are set=0, clear=1 and readback=2. Writing a 1 to set or clear changes that bit. A 0 leaves that bit alone.
- R3: On a pin the controller owns (owner bit 1), `pad_oe` equals the direction bit (1 = output) and `pad_out` equals the output-data bit.
- R4: On a pin a peripheral owns (owner bit 0), `pad_oe` and `pad_out` follow `periph_oe` and `periph_out`, and the controller's direction and data bits have no effect. The pin's level stays readable, and `periph_in` carries the same level as the level register.
- R5: With its filter off, a pad change shows in the level register (address 0x14) after the third rising clock edge that follows it.
- R6: With its filter on, a pin's level changes only after the synchronized input has held the new value on two consecutive samples. This adds one cycle of latency, and a pad pulse one cycle wide is dropped.
- R7: Any change of a pin's level, in either direction, sets that pin's bit in the change register (address 0x15). The bit is set whether or not the interrupt is enabled, and stays set until it is read.
- R8: A read strobe on address 0x15 returns the current change bits and clears them at that edge. A change that arrives at the same edge is kept.
- R9: `irq` is high exactly when some pin has both its change bit and its interrupt-enable bit set.
- R10: Reads of unmapped addresses return 0. Writes to readback, level or change addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for clear-on-read) |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for the current address (combinational) |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| periph_out | input | NPINS | Peripheral output values |
| periph_oe | input | NPINS | Peripheral output enables |
| periph_in | output | NPINS | Conditioned pin level to peripherals |
| irq | output | 1 | Combined change interrupt |

## Verification
Every setting group is swept with walking-one, alternating and all-ones set and clear patterns. These show whether set and clear each touch only the bits they are given, and whether any two groups have become mixed up. The ownership mix is checked with several owner masks under opposite controller and peripheral drive values, so each pad bit shows which source won. Single-cycle and two-cycle pulses, with the filter on and off, separate filter rejection from plain synchronizer delay. Exact-edge sampling of the level tells the two-edge and three-edge paths apart. A change that lands on the same edge as a read shows whether new events win over the clear.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_READ = 2'd2,
        OP_NONE = 2'd3
    } pio_op_e;

    typedef enum logic [2:0] {
        GRP_OWN   = 3'd0,
        GRP_DIR   = 3'd1,
        GRP_DOUT  = 3'd2,
        GRP_FILT  = 3'd3,
        GRP_IRQEN = 3'd4,
        GRP_STAT  = 3'd5,
        GRP_R6    = 3'd6,
        GRP_R7    = 3'd7
    } pio_grp_e;

    localparam int NUM_CFG_GRP = 5;
    localparam int ADDR_W      = 5;

    // operation codes inside the status group
    localparam logic [1:0] STAT_LEVEL = 2'd0;
    localparam logic [1:0] STAT_CHG   = 2'd1;

    typedef struct packed {
        logic     wr;
        logic     rd;
        pio_grp_e grp;
        pio_op_e  op;
    } pio_req_t;

    function automatic pio_req_t pio_decode(input logic wr, input logic rd,
                                            input logic [ADDR_W-1:0] addr);
        pio_req_t r;
        r.wr  = wr;
        r.rd  = rd;
        r.grp = pio_grp_e'(addr[4:2]);
        r.op  = pio_op_e'(addr[1:0]);
        return r;
    endfunction

    function automatic logic is_cfg_grp(input pio_grp_e g);
        return (int'(g) < NUM_CFG_GRP);
    endfunction

endpackage

// File: rtl/pio_setclr_reg.sv
module pio_setclr_reg #(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] set_m, clr_m;

    always_comb begin
        set_m = set_stb ? wdata : '0;
        clr_m = clr_stb ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= (q | set_m) & ~clr_m;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> ((q & $past(wdata)) == $past(wdata))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> ((q & $past(wdata)) == '0)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(q)); // R2

endmodule

// File: rtl/pio_in_lane.sv
module pio_in_lane (
    input  logic clk,
    input  logic rst,
    input  logic pad_i,
    input  logic filt_en,
    output logic lvl_o
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            s3    <= 1'b0;
            lvl_o <= 1'b0;
        end else begin
            s1 <= pad_i;
            s2 <= s1;
            s3 <= s2;
            if (!filt_en)       lvl_o <= s2;
            else if (s2 == s3)  lvl_o <= s2;
        end
    end

    AST_FILT_NEEDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (filt_en && (s2 != s3)) |=> (lvl_o == $past(lvl_o))); // R6
    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !filt_en |=> (lvl_o == $past(s2))); // R5

endmodule

// File: rtl/pio_chg_status.sv
module pio_chg_status #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         clr_stb,
    output logic [W-1:0] status
);
    logic [W-1:0] lvl_prev;
    logic [W-1:0] chg;

    always_comb chg = lvl ^ lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= '0;
            status   <= '0;
        end else begin
            lvl_prev <= lvl;
            status   <= (clr_stb ? '0 : status) | chg;
        end
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_stb |=> ((status & $past(status)) == $past(status))); // R7
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && (lvl == lvl_prev)) |=> (status == '0)); // R8
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (lvl != lvl_prev) |=> ((status & $past(lvl ^ lvl_prev)) == $past(lvl ^ lvl_prev))); // R7

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import pio_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [4:0]        bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_oe,
    output logic [NPINS-1:0]  periph_in,
    output logic              irq
);
    localparam logic [NPINS-1:0] ALL_ONES = '1;

    pio_req_t         req;
    logic [NPINS-1:0] cfg [NUM_CFG_GRP];
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] status;
    logic             chg_clr;

    always_comb req = pio_decode(bus_wr, bus_rd, bus_addr);

    // one set/clear register per setting group
    for (genvar g = 0; g < NUM_CFG_GRP; g++) begin : g_cfg
        localparam logic [NPINS-1:0] RV = (g == int'(GRP_OWN)) ? ALL_ONES : '0;
        logic hit;
        always_comb hit = req.wr && (int'(req.grp) == g);
        pio_setclr_reg #(.W(NPINS), .RST_VAL(RV)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .set_stb (hit && (req.op == OP_SET)),
            .clr_stb (hit && (req.op == OP_CLR)),
            .wdata   (bus_wdata),
            .q       (cfg[g])
        );
    end

    // input conditioning, one lane per pin
    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        pio_in_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .pad_i   (pad_in[i]),
            .filt_en (cfg[GRP_FILT][i]),
            .lvl_o   (level[i])
        );
    end

    always_comb chg_clr = req.rd && (req.grp == GRP_STAT) && (req.op == STAT_CHG);

    pio_chg_status #(.W(NPINS)) u_chg (
        .clk     (clk),
        .rst     (rst),
        .lvl     (level),
        .clr_stb (chg_clr),
        .status  (status)
    );

    // pad ownership mux
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (cfg[GRP_OWN][i]) begin
                pad_oe[i]  = cfg[GRP_DIR][i];
                pad_out[i] = cfg[GRP_DOUT][i];
            end else begin
                pad_oe[i]  = periph_oe[i];
                pad_out[i] = periph_out[i];
            end
        end
    end

    always_comb periph_in = level;
    always_comb irq = |(status & cfg[GRP_IRQEN]);

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (is_cfg_grp(req.grp)) begin
            if (req.op == OP_READ) bus_rdata = cfg[req.grp];
        end else if (req.grp == GRP_STAT) begin
            if (req.op == STAT_LEVEL)    bus_rdata = level;
            else if (req.op == STAT_CHG) bus_rdata = status;
        end
    end

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status != '0)); // R9
    AST_NO_IRQ_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (chg_clr && !$changed(level) && !$changed(status)) |=> !$rose(irq)); // R8

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int NP = 12;
    localparam logic [4:0] A_LVL = 5'h14, A_CHG = 5'h15;

    logic clk = 0, rst = 1;
    logic bus_wr = 0, bus_rd = 0;
    logic [4:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic [NP-1:0] periph_out = '0, periph_oe = '0, periph_in;
    logic irq;

    int n_chk = 0, n_fail = 0;
    logic [NP-1:0] model [5];
    logic [NP-1:0] d;

    gpio_bank #(.NPINS(NP)) dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [NP-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        if (a[4:2] < 5) begin
            if (a[1:0] == 0) model[a[4:2]] = model[a[4:2]] | v;
            if (a[1:0] == 1) model[a[4:2]] = model[a[4:2]] & ~v;
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [NP-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [NP-1:0] pats [4];
        pats[0] = 12'h001; pats[1] = 12'hA5A; pats[2] = 12'h5A5; pats[3] = 12'hFFF;
        model[0] = '1; for (int g = 1; g < 5; g++) model[g] = '0;
        tick(3); rst = 0; tick(1);

        // R1 reset state
        for (int g = 0; g < 5; g++) begin
            rd(5'(g*4+2), d); chk("R1 cfg", d, g == 0 ? '1 : '0);
        end
        rd(A_CHG, d); chk("R1 chg", d, '0);
        chk("R1 oe", pad_oe, '0);
        chk("R1 irq", {11'b0, irq}, '0);

        // R2 set/clear sweeps
        for (int g = 0; g < 5; g++) begin
            for (int p = 0; p < 4; p++) begin
                wr(5'(g*4+0), pats[p]);
                rd(5'(g*4+2), d); chk("R2 set", d, model[g]);
                wr(5'(g*4+1), pats[(p+1)%4]);
                rd(5'(g*4+2), d); chk("R2 clr", d, model[g]);
            end
            wr(5'(g*4+1), '1);
        end
        wr(5'h00, '1);

        // R3 controller-owned pads
        for (int p = 0; p < 4; p++) begin
            wr(5'h04, pats[p]); wr(5'h08, ~pats[p]);
            periph_oe = ~pats[p]; periph_out = pats[p];
            #1 chk("R3 oe", pad_oe, pats[p]);
            chk("R3 out", pad_out, ~pats[p]);
            wr(5'h05, '1); wr(5'h09, '1);
        end

        // R4 peripheral-owned pads
        wr(5'h04, 12'hF0F); wr(5'h08, 12'h3C3);
        for (int p = 0; p < 4; p++) begin
            wr(5'h01, pats[p]);
            periph_oe = 12'h0FF; periph_out = 12'hC3C;
            #1 chk("R4 oe", pad_oe, (model[0] & 12'hF0F) | (~model[0] & 12'h0FF));
            chk("R4 out", pad_out, (model[0] & 12'h3C3) | (~model[0] & 12'hC3C));
            wr(5'h00, '1);
        end
        wr(5'h01, 12'hFFF);
        pad_in = 12'h6A9; tick(5);
        rd(A_LVL, d); chk("R4 level readable", d, 12'h6A9);
        chk("R4 periph_in", periph_in, 12'h6A9);
        pad_in = '0; tick(5); wr(5'h00, '1);
        rd(A_CHG, d);

        // R5 unfiltered latency, per pin
        for (int i = 0; i < NP; i++) begin
            @(negedge clk); pad_in = NP'(1) << i; bus_addr = A_LVL;
            tick(2); #1 chk("R5 before", bus_rdata, '0);
            tick(1); #1 chk("R5 after", bus_rdata, NP'(1) << i);
            pad_in = '0; tick(5);
        end
        rd(A_CHG, d); chk("R7 both edges", d, '1);
        rd(A_CHG, d); chk("R8 cleared", d, '0);

        // R6 filtered latency and pulse rejection
        wr(5'h0C, '1);
        @(negedge clk); pad_in = 12'h00F; bus_addr = A_LVL;
        tick(3); #1 chk("R6 before", bus_rdata, '0);
        tick(1); #1 chk("R6 after", bus_rdata, 12'h00F);
        pad_in = '0; tick(6); rd(A_CHG, d);
        @(negedge clk); pad_in = 12'h0F0; @(negedge clk); pad_in = '0;
        tick(6); rd(A_LVL, d); chk("R6 pulse lvl", d, '0);
        rd(A_CHG, d); chk("R6 pulse dropped", d, '0);
        @(negedge clk); pad_in = 12'h0F0; tick(2); pad_in = '0;
        tick(6); rd(A_CHG, d); chk("R6 2-cycle kept", d, 12'h0F0);
        wr(5'h0D, 12'h0F0);
        @(negedge clk); pad_in = 12'h0F0; @(negedge clk); pad_in = '0;
        tick(6); rd(A_CHG, d); chk("R6 unfiltered pulse seen", d, 12'h0F0);
        wr(5'h0D, '1);

        // R7 / R9 status and irq
        wr(5'h10, 12'h00C);
        @(negedge clk); pad_in = 12'h300; tick(6);
        #1 chk("R9 irq masked", {11'b0, irq}, '0);
        rd(A_CHG, d); chk("R7 set w/o enable", d, 12'h300);
        pad_in = 12'h304; tick(6);
        #1 chk("R9 irq on", {11'b0, irq}, 12'h001);
        rd(A_CHG, d); chk("R7 status", d, 12'h004);
        #1 chk("R9 irq off after read", {11'b0, irq}, '0);

        // R8 change on the same edge as the read
        @(negedge clk); pad_in = 12'h306; tick(6);
        @(negedge clk); pad_in = 12'h307;
        tick(2);
        @(negedge clk); bus_addr = A_CHG; bus_rd = 1;
        #1 chk("R8 read value", bus_rdata, 12'h002);
        @(negedge clk); bus_rd = 0;
        #1 chk("R8 new change kept", bus_rdata, 12'h001);
        rd(A_CHG, d);

        // R10 unmapped and read-only addresses
        wr(5'h06, 12'h555); rd(5'h06, d); chk("R10 ro dir", d, model[1]);
        wr(5'h15, 12'hFFF); rd(A_CHG, d); chk("R10 ro chg", d, '0);
        wr(5'h14, 12'hFFF); rd(A_LVL, d); chk("R10 ro lvl", d, 12'h307);
        for (int a = 0; a < 32; a++) begin
            if ((a < 20 && a[1:0] == 3) || a >= 22) begin
                rd(5'(a), d); chk("R10 unmapped", d, '0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule